// File: doc/BRIEF.md
# Paired-Channel ADC Sequencing Controller

This controller sits on the host side of a six-channel simultaneous-sampling converter that has a parallel read bus. The six channels form three pairs, and each pair has its own active-low convert-start line. A request carries a three-bit pair mask. The controller pulses the start lines of the selected pairs together, so their channels sample at the same instant. It then waits for the converter's busy flag to rise and fall again.

After busy falls, the controller holds chip select low for a single burst. In that burst it issues one read strobe per result (word mode) or two per result (byte mode, high byte first). It reads only the channels of the pairs that were triggered, in ascending channel order. Each result leaves the block as a one-cycle valid pulse, together with the assembled data and a channel number from 1 to 6.

If busy never completes, a timeout returns the controller to idle without reading. All strobe widths and spacings are given in system clock cycles.

Top module: `adc_pair_seq`

## Requirements
- R1: While reset is asserted, and right after it, `ready_o` is 1, `cnvst_n_o` is 3'b111, `cs_n_o` and `rd_n_o` are 1 and `res_valid_o` is 0.
- R2: An accepted request drives low exactly the start lines of the selected pairs for CONV_LOW cycles, and releases them all in the same cycle. Mask bit 0 selects line 0 (channels 1 and 2), bit 1 selects line 1 (channels 3 and 4) and bit 2 selects line 2 (channels 5 and 6).
- R3: No read strobe falls before `busy_i` has been seen high and then low after the start pulse.
- R4: With `word_byte_o` = 0, each selected channel gets one read, so a selected pair gets two, in ascending channel order. The result is `db_i[RES_W-1:0]`.
- R5: With `word_byte_o` = 1, each result takes two reads. The first read returns the high part on `db_i[7:0]` and the second returns bits 7:0. The result is {first[RES_W-9:0], second[7:0]}. `word_byte_o` holds the byte-mode input captured when the request was accepted.
- R6: `rd_n_o` is low only while `cs_n_o` is low, and each read strobe stays low for exactly RD_LOW cycles.
- R7: Each result is shown for exactly one cycle on `res_valid_o`, with `res_chan_o` between 1 and 6.
- R8: If busy has not completed within BUSY_TMO cycles, `timeout_o` pulses for one cycle, the controller is idle (`ready_o` = 1) in that cycle, and no read is issued.
- R9: A request with a zero mask, or any request while `ready_o` is 0, is ignored. `ready_o` is 1 only when no conversion or read is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion cycle |
| pair_mask_i | input | 3 | Pair-select mask for the request |
| byte_mode_i | input | 1 | 1 = byte reads, 0 = word reads |
| ready_o | output | 1 | Idle; a new request can be accepted |
| cnvst_n_o | output | 3 | Active-low convert-start line per pair |
| busy_i | input | 1 | Converter busy flag |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| db_i | input | RES_W | Converter data bus |
| word_byte_o | output | 1 | Read width select to the converter |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | RES_W | Assembled result |
| res_chan_o | output | 3 | Channel number 1..6 of the result |
| timeout_o | output | 1 | One-cycle pulse when busy did not complete |

## Verification
The bench drives requests against a behavioural converter. The converter model serves only the channels whose start lines rose, and it fills the unused high bits of the bus with junk.

Non-contiguous masks catch a controller that reads a skipped pair, or reads the pairs out of order. Byte mode with junk in the unused bits catches swapped byte order and bits that should have been dropped but were kept.

A request made during an active cycle must not cause a second conversion. A silent converter must produce a timeout with no read strobes. A design that treats a low busy flag before the conversion as "done" would read early, and the model flags that.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV, ST_WAIT, ST_SETUP, ST_RDLO, ST_RDHI
  } seq_state_e;

  // expand a pair mask into one bit per channel, channel 1 in bit 0
  function automatic logic [5:0] pairs_to_chans(input logic [2:0] m);
    return {m[2], m[2], m[1], m[1], m[0], m[0]};
  endfunction

  // lowest pending channel as a number 1..6, 0 when none pending
  function automatic logic [2:0] first_chan(input logic [5:0] p);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (p[i]) r = 3'(i + 1);
    return r;
  endfunction

  function automatic logic [5:0] drop_first(input logic [5:0] p);
    return p & (p - 6'd1);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/seq_delay_cnt.sv
module seq_delay_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (ld_i)          cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_result_pack.sv
module seq_result_pack #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             byte_i,
  input  logic             last_part_i,
  input  logic [2:0]       chan_i,
  input  logic [RES_W-1:0] db_i,
  output logic             valid_o,
  output logic [RES_W-1:0] data_o,
  output logic [2:0]       chan_o
);
  localparam int HI_W = RES_W - 8;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      chan_o  <= '0;
    end else begin
      valid_o <= cap_i && last_part_i;
      if (cap_i && !last_part_i) hi_q <= db_i[HI_W-1:0];
      if (cap_i && last_part_i) begin
        data_o <= byte_i ? {hi_q, db_i[7:0]} : db_i;
        chan_o <= chan_i;
      end
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R7
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (chan_o >= 3'd1 && chan_o <= 3'd6));
endmodule

// File: rtl/adc_pair_seq.sv
module adc_pair_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 14,
  parameter int CONV_LOW = 2,
  parameter int CS_SETUP = 1,
  parameter int RD_LOW   = 2,
  parameter int RD_GAP   = 1,
  parameter int BUSY_TMO = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       pair_mask_i,
  input  logic             byte_mode_i,
  output logic             ready_o,
  output logic [2:0]       cnvst_n_o,
  input  logic             busy_i,
  output logic             cs_n_o,
  output logic             rd_n_o,
  input  logic [RES_W-1:0] db_i,
  output logic             word_byte_o,
  output logic             res_valid_o,
  output logic [RES_W-1:0] res_data_o,
  output logic [2:0]       res_chan_o,
  output logic             timeout_o
);
  localparam int MAX_LD = max4(max4(CONV_LOW, CS_SETUP, RD_LOW, RD_GAP), BUSY_TMO, 1, 1);
  localparam int CNT_W  = $clog2(MAX_LD + 1);

  seq_state_e       st_q, st_d;
  logic [5:0]       pend_q;
  logic [2:0]       sel_q;
  logic             byte_q, hi_ph_q, seen_q, tmo_q;
  logic             tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  // named internal events
  logic start_ok_ev, busy_fall_ev, tmo_ev, rd_cap_ev, last_part, burst_end_ev;
  assign start_ok_ev  = (st_q == ST_IDLE) && start_i && (pair_mask_i != 3'b000);
  assign busy_fall_ev = (st_q == ST_WAIT) && seen_q && !busy_i;
  assign tmo_ev       = (st_q == ST_WAIT) && !busy_fall_ev && tmr_zero;
  assign rd_cap_ev    = (st_q == ST_RDLO) && tmr_zero;
  assign last_part    = !byte_q || hi_ph_q;
  assign burst_end_ev = (st_q == ST_RDHI) && tmr_zero && (pend_q == 6'd0);

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    case (st_q)
      ST_IDLE: if (start_ok_ev) begin
        st_d = ST_CONV; tmr_ld = 1'b1; tmr_val = CNT_W'(CONV_LOW - 1);
      end
      ST_CONV: if (tmr_zero) begin
        st_d = ST_WAIT; tmr_ld = 1'b1; tmr_val = CNT_W'(BUSY_TMO - 1);
      end
      ST_WAIT: begin
        if (busy_fall_ev) begin
          st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = CNT_W'(CS_SETUP - 1);
        end else if (tmo_ev) st_d = ST_IDLE;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d = ST_RDLO; tmr_ld = 1'b1; tmr_val = CNT_W'(RD_LOW - 1);
      end
      ST_RDLO: if (tmr_zero) begin
        st_d = ST_RDHI; tmr_ld = 1'b1; tmr_val = CNT_W'(RD_GAP - 1);
      end
      ST_RDHI: if (tmr_zero) begin
        if (pend_q == 6'd0) st_d = ST_IDLE;
        else begin
          st_d = ST_RDLO; tmr_ld = 1'b1; tmr_val = CNT_W'(RD_LOW - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      sel_q   <= '0;
      byte_q  <= 1'b0;
      hi_ph_q <= 1'b0;
      seen_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmo_q <= tmo_ev;
      if (start_ok_ev) begin
        sel_q   <= pair_mask_i;
        pend_q  <= pairs_to_chans(pair_mask_i);
        byte_q  <= byte_mode_i;
        hi_ph_q <= 1'b0;
      end
      if (st_q == ST_CONV) seen_q <= 1'b0;
      else if (st_q == ST_WAIT && busy_i) seen_q <= 1'b1;
      if (rd_cap_ev) begin
        hi_ph_q <= !last_part;
        if (last_part) pend_q <= drop_first(pend_q);
      end
    end
  end

  seq_delay_cnt #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  seq_result_pack #(.RES_W(RES_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .cap_i(rd_cap_ev), .byte_i(byte_q),
    .last_part_i(last_part), .chan_i(first_chan(pend_q)), .db_i(db_i),
    .valid_o(res_valid_o), .data_o(res_data_o), .chan_o(res_chan_o)
  );

  assign ready_o     = (st_q == ST_IDLE);
  assign cnvst_n_o   = (st_q == ST_CONV) ? ~sel_q : 3'b111;
  assign cs_n_o      = !(st_q == ST_SETUP || st_q == ST_RDLO || st_q == ST_RDHI);
  assign rd_n_o      = !(st_q == ST_RDLO);
  assign word_byte_o = byte_q;
  assign timeout_o   = tmo_q;

  // R6
  rd_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !cs_n_o);
  // R2
  conv_release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnvst_n_o) != 3'b111 && cnvst_n_o != $past(cnvst_n_o)) |-> cnvst_n_o == 3'b111);
  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (ready_o && rd_n_o && cs_n_o));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cs_n_o && rd_n_o && cnvst_n_o == 3'b111));
  // R3
  no_read_before_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_o) |-> !busy_i);
endmodule

// File: tb/test_adc_pair_seq.sv
module test_adc_pair_seq;
  localparam int RES_W = 14, CONV_LOW = 3, CS_SETUP = 2, RD_LOW = 3, RD_GAP = 2;
  localparam int BUSY_TMO = 64, CONV_CYC = 20;
  localparam logic [15:0] RMASK = 16'((1 << RES_W) - 1);

  logic clk = 0, rst_n = 0, start_i = 0, byte_mode_i = 0, busy_i = 0;
  logic [2:0] pair_mask_i = 0;
  logic [RES_W-1:0] db_i = 0;
  logic ready_o, cs_n_o, rd_n_o, word_byte_o, res_valid_o, timeout_o;
  logic [2:0] cnvst_n_o, res_chan_o;
  logic [RES_W-1:0] res_data_o;

  always #5 clk = ~clk;

  adc_pair_seq #(.RES_W(RES_W), .CONV_LOW(CONV_LOW), .CS_SETUP(CS_SETUP),
    .RD_LOW(RD_LOW), .RD_GAP(RD_GAP), .BUSY_TMO(BUSY_TMO)) i_adc_pair_seq (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [15:0] vals [1:6];
  bit model_en = 1;
  logic [2:0] cn_prev = 3'b111, pairs_m = 0;
  logic rd_prev = 1;
  int bcnt = 0, rd_ptr = 0, rd_tot = 0, conv_cnt = 0, err_early = 0, err_cs = 0, err_w = 0, rd_w = 0;

  function automatic logic [RES_W-1:0] model_word(input int ptr, input logic [2:0] pm, input logic bm);
    int r, k;
    logic [15:0] v;
    r = bm ? ptr / 2 : ptr;
    k = 0;
    v = 0;
    for (int ch = 1; ch <= 6; ch++)
      if (pm[(ch - 1) / 2]) begin
        if (k == r) v = vals[ch] & RMASK;
        k++;
      end
    if (!bm) return RES_W'(v);
    if (ptr % 2 == 0) return RES_W'({8'h2D, v[15:8]});
    return RES_W'({8'h2D, v[7:0]});
  endfunction

  always @(posedge clk) begin
    cn_prev <= cnvst_n_o;
    rd_prev <= rd_n_o;
    if (model_en && ((cnvst_n_o & ~cn_prev) != 0)) begin
      pairs_m <= cnvst_n_o & ~cn_prev;
      busy_i <= 1; bcnt <= CONV_CYC; rd_ptr <= 0; conv_cnt <= conv_cnt + 1;
    end else if (busy_i) begin
      if (bcnt == 0) busy_i <= 0; else bcnt <= bcnt - 1;
    end
    if (!rd_n_o) rd_w <= rd_w + 1;
    if (rd_prev && !rd_n_o) begin
      if (busy_i) err_early <= err_early + 1;
      if (cs_n_o) err_cs <= err_cs + 1;
      db_i <= model_word(rd_ptr, pairs_m, word_byte_o);
      rd_ptr <= rd_ptr + 1; rd_tot <= rd_tot + 1; rd_w <= 1;
    end
    if (!rd_prev && rd_n_o && rd_w != RD_LOW) err_w <= err_w + 1;
  end

  // ---------------- scoreboard ----------------
  int exp_ch[$];
  int exp_v[$];
  always @(negedge clk) begin
    if (rst_n && res_valid_o) begin
      if (exp_ch.size() == 0) chk(0, "R7 unexpected result chan", res_chan_o, 0);
      else begin
        int ec, ev;
        ec = exp_ch.pop_front();
        ev = exp_v.pop_front();
        chk(res_chan_o == ec, "R4/R5 result channel", res_chan_o, ec);
        chk(res_data_o == ev, "R4/R5 result data", res_data_o, ev);
      end
    end
  end

  task automatic run_conv(input logic [2:0] m, input logic b, input int seed, input bit poke);
    int rd0, c0, low, nres;
    rd0 = rd_tot; c0 = conv_cnt; nres = 0;
    for (int ch = 1; ch <= 6; ch++) begin
      vals[ch] = 16'(seed * 2731 + ch * 977 + 16'h0F3);
      if (m[(ch - 1) / 2]) begin
        exp_ch.push_back(ch);
        exp_v.push_back(int'(vals[ch] & RMASK));
        nres++;
      end
    end
    @(negedge clk); start_i = 1; pair_mask_i = m; byte_mode_i = b;
    @(negedge clk); start_i = 0;
    chk(cnvst_n_o == ~m, "R2 selected start lines low", cnvst_n_o, ~m);
    chk(word_byte_o == b, "R5 word_byte_o follows request", word_byte_o, b);
    low = 0;
    while (cnvst_n_o != 3'b111) begin low++; @(negedge clk); end
    chk(low == CONV_LOW, "R2 start low width", low, CONV_LOW);
    if (poke) begin
      chk(ready_o == 0, "R9 ready low while active", ready_o, 0);
      start_i = 1; pair_mask_i = 3'b111;
      @(negedge clk); start_i = 0;
    end
    while (!ready_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rd_tot - rd0 == nres * (b ? 2 : 1), "R4/R5 read count", rd_tot - rd0, nres * (b ? 2 : 1));
    chk(conv_cnt - c0 == 1, "R9 one conversion per request", conv_cnt - c0, 1);
    chk(exp_ch.size() == 0, "R7 all results delivered", exp_ch.size(), 0);
    chk(err_early == 0 && err_cs == 0, "R3/R6 read timing", err_early + err_cs, 0);
    chk(err_w == 0, "R6 read strobe width", err_w, 0);
  endtask

  initial begin
    int cyc, r0, c0;
    bit seen_to;
    repeat (3) @(negedge clk);
    // R1
    chk(ready_o && cnvst_n_o == 3'b111 && cs_n_o && rd_n_o && !res_valid_o,
        "R1 reset state", {ready_o, cnvst_n_o, cs_n_o, rd_n_o, res_valid_o}, 7'b1111110);
    rst_n = 1;
    @(negedge clk);
    chk(ready_o, "R1 ready after reset", ready_o, 1);
    run_conv(3'b101, 0, 1, 0);
    run_conv(3'b111, 1, 2, 0);
    run_conv(3'b010, 0, 3, 0);
    run_conv(3'b001, 1, 4, 0);
    run_conv(3'b110, 1, 5, 1);
    run_conv(3'b111, 0, 6, 0);
    // R9 zero mask
    c0 = conv_cnt;
    @(negedge clk); start_i = 1; pair_mask_i = 0;
    @(negedge clk); start_i = 0;
    repeat (10) begin
      chk(ready_o && cnvst_n_o == 3'b111, "R9 zero mask ignored", {ready_o, cnvst_n_o}, 4'b1111);
      @(negedge clk);
    end
    chk(conv_cnt == c0, "R9 zero mask no conversion", conv_cnt, c0);
    // R8 timeout with a silent converter
    model_en = 0; r0 = rd_tot; seen_to = 0; cyc = 0;
    @(negedge clk); start_i = 1; pair_mask_i = 3'b011;
    @(negedge clk); start_i = 0;
    while (!seen_to && cyc < BUSY_TMO + 20) begin
      if (timeout_o) begin
        seen_to = 1;
        chk(ready_o, "R8 idle at timeout", ready_o, 1);
      end
      cyc++;
      @(negedge clk);
    end
    chk(seen_to, "R8 timeout pulse", seen_to, 1);
    chk(!timeout_o, "R8 timeout one cycle", timeout_o, 0);
    chk(rd_tot == r0, "R8 no reads on timeout", rd_tot, r0);
    model_en = 1;
    run_conv(3'b100, 1, 7, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      chk(0, "watchdog expired", wd, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule